// File: doc/BRIEF.md
# Time-Slot PCM Serial Port

This block carries one 8-bit voice sample per frame between a codec core and a time-division PCM bus. The bus supplies a bit clock, a frame sync and a serial receive line; the block returns a serial transmit line with an output enable that stands in for a tri-state driver. The three bus inputs are brought into the system clock domain through a synchronizer. Frame start comes from the rising edge of the frame sync only. A bit position counter then places one of two 8-bit voice slots within the frame.

Configuration inputs choose the frame timing (non-delayed or delayed), the slot layout (back-to-back slots, or a second slot pushed two bit periods later to leave room for a signalling channel), the slot used, and whether voice transfer is on. The transmit byte is taken from the core at each frame start. It is sent MSB first on rising bit-clock edges. The receive byte is sampled on falling edges and held in a readable register, with a one-cycle strobe.

A byte written through the override port replaces the core byte for exactly one frame. After power-up the output stays disabled until the second frame sync.

Top module: `pcm_slot_port`

## Requirements
- R1: Only a rising edge of the frame sync, as seen at a rising bit-clock edge, starts a frame. The sync may stay high for any number of bit clocks, from one up to nearly the whole frame, with identical results.
- R2: With `cfg_delayed`=0 the first slot starts at the bit clock where the frame sync rise is seen (bit position 0). With `cfg_delayed`=1 it starts one bit clock later (position 1).
- R3: Slot B2 (`cfg_slot_b2`=1) starts 8 bit positions after the first-slot start when `cfg_fmt2`=0, and 10 positions after it when `cfg_fmt2`=1. Slot B1 (`cfg_slot_b2`=0) is the first slot itself. Each slot is 8 bit positions long.
- R4: Within the selected slot, `pcm_tx` carries the frame's transmit byte MSB first, one bit per bit clock. It changes only after a rising bit-clock edge.
- R5: `pcm_tx_oe` is 1 only during the 8 bit positions of the selected slot, and 0 in every other position of the frame.
- R6: While `cfg_en`=0, `pcm_tx_oe` stays 0, `rx_valid` never pulses, and `rx_byte` keeps its previous value.
- R7: Inside the selected slot, `pcm_rx` is sampled on falling bit-clock edges, MSB first. After the eighth bit, `rx_byte` holds the received byte and `rx_valid` is 1 for exactly one clock cycle.
- R8: After `pwr_up` rises, `pcm_tx_oe` stays 0 through the frame opened by the first frame sync. It becomes active from the frame opened by the second frame sync.
- R9: When `pwr_up` is 0 for two consecutive cycles, `pcm_tx_oe` is 0 from the next cycle on.
- R10: A pulse on `ovr_wr` stores `ovr_byte`. The next frame transmits that byte in place of `core_tx_byte`. The frame after it transmits `core_tx_byte` again, unless a new write has occurred.
- R11: After reset, `pcm_tx_oe`, `pcm_tx` and `rx_valid` are 0 and `rx_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pcm_bclk | input | 1 | PCM bus bit clock |
| pcm_fs | input | 1 | PCM bus frame sync |
| pcm_rx | input | 1 | PCM serial receive data |
| pcm_tx | output | 1 | PCM serial transmit data |
| pcm_tx_oe | output | 1 | Transmit output enable (1 = drive bus) |
| cfg_delayed | input | 1 | 1 = delayed frame timing |
| cfg_fmt2 | input | 1 | 1 = two-bit gap before slot B2 |
| cfg_slot_b2 | input | 1 | 1 = use slot B2, 0 = slot B1 |
| cfg_en | input | 1 | Voice transfer enable |
| pwr_up | input | 1 | 1 = powered up |
| core_tx_byte | input | 8 | Transmit byte from the codec core |
| ovr_wr | input | 1 | One-cycle write strobe for the override byte |
| ovr_byte | input | 8 | Override transmit byte |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |

## Verification
The bench sweeps every combination of timing mode, slot layout and slot choice. For each it records the full per-position enable pattern of a 32-bit frame. A wrong base offset or gap width shows up as a mask shifted by one or two positions. A design that restarts on frame-sync level instead of edge fails the long-sync vectors by re-opening the frame. A bit-order swap corrupts the transmitted and received bytes. The one-shot override is checked over two frames: a design that keeps the override sticky transmits it twice. The power-up gate is checked frame by frame: a design that counts only one sync opens the output a frame early. Disabled transfer must leave the previously received byte untouched.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int DATA_W = 8;
  localparam int POS_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int GAP_W  = 2;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] byte_t;

  // First bit position of the chosen slot, counted from the frame-sync edge.
  function automatic pos_t slot_base(input logic delayed, input logic fmt2,
                                     input logic slot_b2);
    pos_t b;
    b = delayed ? pos_t'(1) : pos_t'(0);
    if (slot_b2) b = b + (fmt2 ? pos_t'(DATA_W + GAP_W) : pos_t'(DATA_W));
    return b;
  endfunction

  function automatic logic in_window(input pos_t pos, input pos_t base);
    return (pos >= base) && ((pos - base) < pos_t'(DATA_W));
  endfunction

  // Bit of the byte carried at this position, MSB first.
  function automatic idx_t bit_index(input pos_t pos, input pos_t base);
    pos_t d;
    d = pos - base;
    return idx_t'(DATA_W - 1) - d[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fs_in,
  input  logic rx_in,
  output logic rise_evt,
  output logic fall_evt,
  output logic fs_lvl,
  output logic rx_lvl
);
  localparam int LANES = 3;

  logic [STAGES-1:0][LANES-1:0] chain;
  logic [LANES-1:0]             tail;
  logic                         bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      bclk_d <= 1'b0;
    end else begin
      chain[0] <= {bclk_in, fs_in, rx_in};
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      bclk_d <= tail[2];
    end
  end

  assign tail     = chain[STAGES-1];
  assign rise_evt = tail[2] & ~bclk_d;
  assign fall_evt = ~tail[2] & bclk_d;
  assign fs_lvl   = tail[1];
  assign rx_lvl   = tail[0];
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic fs_lvl,
  input  logic pwr_up,
  output pos_t pos,
  output logic tick,
  output logic frame_tick,
  output logic live
);
  logic fs_prev;
  logic armed;
  logic fs_edge;

  assign fs_edge = rise_evt & fs_lvl & ~fs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '1;
      tick       <= 1'b0;
      frame_tick <= 1'b0;
      fs_prev    <= 1'b0;
      armed      <= 1'b0;
      live       <= 1'b0;
    end else begin
      tick       <= rise_evt;
      frame_tick <= fs_edge;
      if (rise_evt) begin
        fs_prev <= fs_lvl;
        if (fs_edge)         pos <= '0;
        else if (pos != '1)  pos <= pos + 1'b1;
      end
      if (!pwr_up) begin
        armed <= 1'b0;
        live  <= 1'b0;
      end else if (fs_edge) begin
        armed <= 1'b1;
        if (armed) live <= 1'b1;
      end
    end
  end

  p_live_opens_on_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> frame_tick);
  p_live_drops_when_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> !live);
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter
  import pcm_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  frame_tick,
  input  logic  fall_evt,
  input  logic  rx_lvl,
  input  logic  live,
  input  pos_t  pos,
  input  logic  cfg_delayed,
  input  logic  cfg_fmt2,
  input  logic  cfg_slot_b2,
  input  logic  cfg_en,
  input  byte_t core_tx_byte,
  input  logic  ovr_wr,
  input  byte_t ovr_byte,
  output logic  tx_data,
  output logic  tx_oe,
  output byte_t rx_byte,
  output logic  rx_valid
);
  pos_t  base;
  logic  slot_hit;
  idx_t  slot_idx;
  byte_t cur_q, cur_n, ovr_q, rx_sh;
  logic  ovr_pend;

  assign base     = slot_base(cfg_delayed, cfg_fmt2, cfg_slot_b2);
  assign slot_hit = in_window(pos, base);
  assign slot_idx = bit_index(pos, base);
  assign cur_n    = frame_tick ? (ovr_pend ? ovr_q : core_tx_byte) : cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      ovr_q    <= '0;
      ovr_pend <= 1'b0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_data  <= 1'b0;
      tx_oe    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (ovr_wr) begin
        ovr_q    <= ovr_byte;
        ovr_pend <= 1'b1;
      end else if (frame_tick) begin
        ovr_pend <= 1'b0;
      end
      if (tick) begin
        cur_q   <= cur_n;
        tx_data <= slot_hit & cur_n[slot_idx];
        tx_oe   <= slot_hit & cfg_en & live;
      end else if (!live || !cfg_en) begin
        tx_oe   <= 1'b0;
      end
      if (fall_evt && slot_hit && cfg_en) begin
        rx_sh <= {rx_sh[DATA_W-2:0], rx_lvl};
        if (slot_idx == '0) begin
          rx_byte  <= {rx_sh[DATA_W-2:0], rx_lvl};
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_tx_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx_data));
  p_rx_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rx_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(cfg_en));
  p_override_one_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !ovr_wr |=> !ovr_pend);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcm_bclk,
  input  logic              pcm_fs,
  input  logic              pcm_rx,
  output logic              pcm_tx,
  output logic              pcm_tx_oe,
  input  logic              cfg_delayed,
  input  logic              cfg_fmt2,
  input  logic              cfg_slot_b2,
  input  logic              cfg_en,
  input  logic              pwr_up,
  input  logic [DATA_W-1:0] core_tx_byte,
  input  logic              ovr_wr,
  input  logic [DATA_W-1:0] ovr_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid
);
  logic rise_evt, fall_evt, fs_lvl, rx_lvl;
  logic tick, frame_tick, live;
  pos_t pos;

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_in(pcm_bclk), .fs_in(pcm_fs), .rx_in(pcm_rx),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .fs_lvl(fs_lvl), .rx_lvl(rx_lvl)
  );

  pcm_frame_timer u_timer (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fs_lvl(fs_lvl), .pwr_up(pwr_up),
    .pos(pos), .tick(tick), .frame_tick(frame_tick), .live(live)
  );

  pcm_slot_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_tick(frame_tick),
    .fall_evt(fall_evt), .rx_lvl(rx_lvl), .live(live), .pos(pos),
    .cfg_delayed(cfg_delayed), .cfg_fmt2(cfg_fmt2), .cfg_slot_b2(cfg_slot_b2),
    .cfg_en(cfg_en), .core_tx_byte(core_tx_byte), .ovr_wr(ovr_wr),
    .ovr_byte(ovr_byte), .tx_data(pcm_tx), .tx_oe(pcm_tx_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  p_quiet_when_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up ##1 !pwr_up |=> !pcm_tx_oe);
endmodule

// File: tb/test_pcm_slot_port.sv
module test_pcm_slot_port;
  localparam int HB = 8;
  localparam int NB = 32;
  localparam int NV = 8;
  // {delayed, fmt2, slot_b2, fs_width[5:0], core byte, rx byte}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 6'd1,  8'hA5, 8'h3C},
    {1'b0, 1'b0, 1'b1, 6'd1,  8'h81, 8'h7E},
    {1'b0, 1'b1, 1'b1, 6'd16, 8'h96, 8'hE1},
    {1'b1, 1'b0, 1'b0, 6'd1,  8'h0F, 8'hF0},
    {1'b1, 1'b0, 1'b1, 6'd5,  8'hC3, 8'h55},
    {1'b1, 1'b1, 1'b1, 6'd16, 8'h69, 8'h18},
    {1'b0, 1'b1, 1'b0, 6'd31, 8'hFE, 8'h01},
    {1'b1, 1'b1, 1'b0, 6'd2,  8'h33, 8'hCC}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pcm_bclk = 1'b0, pcm_fs = 1'b0, pcm_rx = 1'b0;
  logic cfg_delayed = 1'b0, cfg_fmt2 = 1'b0, cfg_slot_b2 = 1'b0, cfg_en = 1'b0;
  logic pwr_up = 1'b0, ovr_wr = 1'b0;
  logic [7:0] core_tx_byte = 8'h00, ovr_byte = 8'h00;
  logic pcm_tx, pcm_tx_oe, rx_valid;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, nval_tot = 0;

  pcm_slot_port i_pcm_slot_port (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (rx_valid === 1'b1) nval_tot++;

  function automatic int exp_base(logic d, logic f2, logic b2);
    return (d ? 1 : 0) + (b2 ? (f2 ? 10 : 8) : 0);
  endfunction

  function automatic logic [31:0] slot_mask(int base);
    return 32'h0000_00FF << base;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic bit_cycle(logic fs_next, logic rxv, output logic oe_s, output logic tx_s);
    pcm_bclk = 1'b1;
    pcm_rx   = rxv;
    wait_clk(HB);
    pcm_bclk = 1'b0;
    pcm_fs   = fs_next;
    wait_clk(HB);
    oe_s = pcm_tx_oe;
    tx_s = pcm_tx;
  endtask

  task automatic run_frame(int fsw, logic [7:0] rxb, output logic [31:0] oem,
                           output logic [7:0] txv, output int nv);
    int base;
    int v0;
    base = exp_base(cfg_delayed, cfg_fmt2, cfg_slot_b2);
    v0   = nval_tot;
    oem  = '0;
    txv  = '0;
    for (int e = 0; e < NB; e++) begin
      logic insl, rxv, fsn, o, t;
      insl = (e >= base) && (e < base + 8);
      rxv  = insl ? rxb[7 - (e - base)] : e[0];
      fsn  = (e == NB - 1) || (e < fsw - 1);
      bit_cycle(fsn, rxv, o, t);
      oem[e] = o;
      if (insl) txv[7 - (e - base)] = t;
    end
    nv = nval_tot - v0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] oem;
    logic [7:0]  txv;
    logic [7:0]  prev_rx;
    int nv;
    logic o, t;

    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    check("R11 reset outputs oe/tx/valid/rx_byte",
          {21'd0, pcm_tx_oe, pcm_tx, rx_valid, rx_byte}, 32'h0);

    // power-up sequence: first sync silent, second opens output
    cfg_en = 1'b1;
    core_tx_byte = 8'h3A;
    pwr_up = 1'b1;
    wait_clk(2);
    bit_cycle(1'b1, 1'b0, o, t);
    run_frame(1, 8'h00, oem, txv, nv);
    check("R8 frame of first sync stays silent", oem, 32'h0);
    run_frame(1, 8'h5B, oem, txv, nv);
    check("R8 frame of second sync drives slot", oem, slot_mask(0));
    check("R4 transmit byte after power-up", {24'd0, txv}, 32'h3A);
    check("R7 receive byte after power-up", {24'd0, rx_byte}, 32'h5B);

    // vector table: timing mode, format, slot, sync width
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      int fsw;
      v = VEC[i];
      cfg_delayed  = v[24];
      cfg_fmt2     = v[23];
      cfg_slot_b2  = v[22];
      fsw          = int'(v[21:16]);
      core_tx_byte = v[15:8];
      run_frame(fsw, v[7:0], oem, txv, nv);
      check($sformatf("R1 R2 R3 R5 enable mask vec %0d fs width %0d", i, fsw), oem,
            slot_mask(exp_base(v[24], v[23], v[22])));
      check($sformatf("R4 transmit byte vec %0d", i), {24'd0, txv}, {24'd0, v[15:8]});
      check($sformatf("R7 receive byte vec %0d", i), {24'd0, rx_byte}, {24'd0, v[7:0]});
      check($sformatf("R7 one strobe per frame vec %0d", i), nv, 1);
    end

    // override: one frame only
    cfg_delayed = 1'b0; cfg_fmt2 = 1'b0; cfg_slot_b2 = 1'b0;
    core_tx_byte = 8'h11;
    ovr_byte = 8'hA7;
    ovr_wr = 1'b1;
    wait_clk(1);
    ovr_wr = 1'b0;
    run_frame(1, 8'h22, oem, txv, nv);
    check("R10 override byte replaces core byte", {24'd0, txv}, 32'hA7);
    run_frame(1, 8'h4D, oem, txv, nv);
    check("R10 core byte returns next frame", {24'd0, txv}, 32'h11);
    prev_rx = rx_byte;

    // enable off
    cfg_en = 1'b0;
    run_frame(1, 8'hC3, oem, txv, nv);
    check("R6 output disabled", oem, 32'h0);
    check("R6 no receive strobe", nv, 0);
    check("R6 receive byte held", {24'd0, rx_byte}, {24'd0, prev_rx});
    cfg_en = 1'b1;

    // power down, then power up again
    pwr_up = 1'b0;
    run_frame(1, 8'h77, oem, txv, nv);
    check("R9 output off while powered down", oem, 32'h0);
    pwr_up = 1'b1;
    run_frame(1, 8'h78, oem, txv, nv);
    check("R8 first sync after re-power silent", oem, 32'h0);
    run_frame(1, 8'h79, oem, txv, nv);
    check("R8 second sync after re-power active", oem, slot_mask(0));
    check("R4 transmit byte after re-power", {24'd0, txv}, 32'h11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule